// File: doc/BRIEF.md
# Machine-Cycle Bus Request Generator

This block sits beside the sequencer of an 8-bit processor core with a 16-bit address space. Each clock in which the sequencer raises `req`, the block reads the class of the instruction being executed and the current machine-cycle number. From these it works out which bus transaction that machine cycle needs, which address the transaction carries and, for writes and port outputs, which byte goes out. The choice follows the memory-operand conventions of the instruction set. The first machine cycle always fetches at the program counter. Immediate bytes are read at the program counter. Memory operands use the HL pair. Indirect accumulator loads and stores use BC or DE. Direct loads and stores use a 16-bit address that the sequencer has already assembled.

The result is registered, so the cycle code, address and data hold steady for the whole bus cycle that follows. A class and cycle-number pair that the instruction set does not define yields the idle code. It also sets an illegal-sequence flag, which stays set until reset. Instruction decode, the ALU and the bus timing are handled elsewhere.

Top module: `bus_cycle_gen`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it, `cyc` is NONE (0), `addr` and `dout` are zero and `illegal` is low.
- R2: For machine cycle 1, every class issues READ (1) at `pc`, except class INTA (15), which issues INTA (5) at `pc`.
- R3: Class MOVMR (1), in machine cycle 2, issues WRITE (2) at `hl`, with `src` as the data.
- R4: In machine cycle 2, classes IMM1 (3), IMM2 (4), LDA (5), STA (6), MVIM (9), IN (12) and OUT (13) issue READ at `pc`. In machine cycle 3, classes IMM2, LDA and STA issue READ at `pc`.
- R5: In machine cycle 2, classes MOVRM (2), MEMALU (7) and MEMRMW (8) issue READ at `hl`. In machine cycle 3, class MEMRMW issues WRITE at `hl` with `tmp` as the data.
- R6: Class MVIM (9), in machine cycle 3, issues WRITE at `hl` with `tmp` as the data.
- R7: In machine cycle 2, class LDAX (10) issues READ and class STAX (11) issues WRITE with `acc` as the data. The address is `bc` when `pair_sel` is 0 and `de` when it is 1.
- R8: In machine cycle 4, class LDA issues READ at `direct_addr`, and class STA issues WRITE at `direct_addr` with `acc` as the data.
- R9: In machine cycle 3, class IN issues PIN (3) and class OUT issues POUT (4). Both put the port number `tmp` on both address bytes. POUT carries `acc` as the data and PIN carries data 0.
- R10: Class HLT (14), in machine cycle 2, issues HLTA (6) at `pc`.
- R11: `dout` is 0 for every cycle code except WRITE and POUT. When `req` is low, the next outputs are NONE with zero address and data.
- R12: Any other class and machine-cycle pair (this includes cycle numbers 0, 5, 6 and 7) gives NONE with zero address and data when requested, and sets `illegal`. Once set, `illegal` stays high until reset.
- R13: Outputs change only at the clock edge that follows the request. A change on the inputs between edges does not show at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Evaluate a machine cycle this clock |
| op_class | input | 4 | Instruction class code |
| mcyc | input | 3 | Machine-cycle number, 1 to 5 |
| pair_sel | input | 1 | 0 selects BC, 1 selects DE |
| pc | input | 16 | Program counter |
| hl | input | 16 | HL register pair |
| bc | input | 16 | BC register pair |
| de | input | 16 | DE register pair |
| direct_addr | input | 16 | Assembled direct address |
| acc | input | 8 | Accumulator |
| tmp | input | 8 | Temporary register |
| src | input | 8 | Selected source register value |
| cyc | output | 3 | Bus cycle code |
| addr | output | 16 | Bus address |
| dout | output | 8 | Write or output data |
| illegal | output | 1 | Sticky undefined-sequence flag |

## Verification
A wrong address-source choice or a wrong direction shows up in `cyc`, `addr` or `dout` exactly one clock after the request, because there is only one register stage. A per-clock comparison therefore catches it in the same cycle it occurs. A fault in the sticky flag shows either as `illegal` staying low after an undefined pair is requested, or as `illegal` dropping on a later legal request, and the comparison also catches this on the next edge. Adding an inter-edge probe shows whether any output path bypasses the register.

// File: rtl/bus_cycle_gen.sv
module bus_cycle_gen #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [3:0]    op_class,
  input  logic [2:0]    mcyc,
  input  logic          pair_sel,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] hl,
  input  logic [AW-1:0] bc,
  input  logic [AW-1:0] de,
  input  logic [AW-1:0] direct_addr,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] tmp,
  input  logic [DW-1:0] src,
  output logic [2:0]    cyc,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          illegal
);
  localparam logic [2:0] CY_NONE = 3'd0, CY_RD = 3'd1, CY_WR = 3'd2,
                         CY_IN = 3'd3, CY_OUT = 3'd4, CY_INTA = 3'd5,
                         CY_HLTA = 3'd6;

  localparam logic [3:0] K_MOVMR = 4'd1, K_MOVRM = 4'd2, K_IMM1 = 4'd3,
                         K_IMM2 = 4'd4, K_LDA = 4'd5, K_STA = 4'd6,
                         K_MEMALU = 4'd7, K_MEMRMW = 4'd8, K_MVIM = 4'd9,
                         K_LDAX = 4'd10, K_STAX = 4'd11, K_IN = 4'd12,
                         K_OUT = 4'd13, K_HLT = 4'd14, K_INTA = 4'd15;

  logic [2:0]    n_cyc;
  logic [AW-1:0] n_addr;
  logic [DW-1:0] n_data;
  logic          bad;
  logic [AW-1:0] pair;

  assign pair = pair_sel ? de : bc;

  always_comb begin
    n_cyc  = CY_NONE;
    n_addr = '0;
    n_data = '0;
    bad    = 1'b0;
    if (mcyc == 3'd1) begin
      n_cyc  = (op_class == K_INTA) ? CY_INTA : CY_RD;
      n_addr = pc;
    end else if (mcyc == 3'd2) begin
      case (op_class)
        K_MOVMR: begin n_cyc = CY_WR; n_addr = hl; n_data = src; end
        K_MOVRM, K_MEMALU, K_MEMRMW: begin n_cyc = CY_RD; n_addr = hl; end
        K_IMM1, K_IMM2, K_LDA, K_STA, K_MVIM, K_IN, K_OUT:
          begin n_cyc = CY_RD; n_addr = pc; end
        K_LDAX:  begin n_cyc = CY_RD; n_addr = pair; end
        K_STAX:  begin n_cyc = CY_WR; n_addr = pair; n_data = acc; end
        K_HLT:   begin n_cyc = CY_HLTA; n_addr = pc; end
        default: bad = 1'b1;
      endcase
    end else if (mcyc == 3'd3) begin
      case (op_class)
        K_IMM2, K_LDA, K_STA: begin n_cyc = CY_RD; n_addr = pc; end
        K_MEMRMW, K_MVIM: begin n_cyc = CY_WR; n_addr = hl; n_data = tmp; end
        K_IN:    begin n_cyc = CY_IN;  n_addr = {tmp, tmp}; end
        K_OUT:   begin n_cyc = CY_OUT; n_addr = {tmp, tmp}; n_data = acc; end
        default: bad = 1'b1;
      endcase
    end else if (mcyc == 3'd4) begin
      case (op_class)
        K_LDA:   begin n_cyc = CY_RD; n_addr = direct_addr; end
        K_STA:   begin n_cyc = CY_WR; n_addr = direct_addr; n_data = acc; end
        default: bad = 1'b1;
      endcase
    end else begin
      bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc     <= CY_NONE;
      addr    <= '0;
      dout    <= '0;
      illegal <= 1'b0;
    end else if (req) begin
      cyc     <= n_cyc;
      addr    <= n_addr;
      dout    <= n_data;
      illegal <= illegal | bad;
    end else begin
      cyc  <= CY_NONE;
      addr <= '0;
      dout <= '0;
    end
  end
endmodule

module bus_cycle_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [3:0]  op_class,
  input logic [2:0]  mcyc,
  input logic [15:0] pc,
  input logic [2:0]  cyc,
  input logic [15:0] addr,
  input logic [7:0]  dout,
  input logic        illegal
);
  // R12
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  // R11
  idle_when_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (cyc == 3'd0 && addr == 16'd0 && dout == 8'd0));

  // R11
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 3'd2 && cyc != 3'd4) |-> dout == 8'd0);

  // R2
  fetch_at_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mcyc == 3'd1 && op_class != 4'd15) |=> (cyc == 3'd1 && addr == $past(pc)));

  // R9
  port_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3'd3 || cyc == 3'd4) |-> addr[15:8] == addr[7:0]);

  // R12
  none_means_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (cyc != 3'd0 || illegal));
endmodule

bind bus_cycle_gen bus_cycle_gen_chk u_chk (.*);

// File: tb/bus_cycle_gen_tb.sv
module bus_cycle_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  op_class = '0;
  logic [2:0]  mcyc = '0;
  logic        pair_sel = 1'b0;
  logic [15:0] pc = '0, hl = '0, bc = '0, de = '0, direct_addr = '0;
  logic [7:0]  acc = '0, tmp = '0, src = '0;
  logic [2:0]  cyc;
  logic [15:0] addr;
  logic [7:0]  dout;
  logic        illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state: expected values after the next edge
  int    e_cyc = 0, e_addr = 0, e_data = 0;
  bit    e_ill = 0, m_ill = 0;
  string e_tag = "R1";

  always #2 clk = ~clk;

  bus_cycle_gen u_dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "cyc", int'(cyc), e_cyc);
    chk(tag, "addr", int'(addr), e_addr);
    chk(tag, "dout", int'(dout), e_data);
    chk(e_ill ? "R12" : tag, "illegal", int'(illegal), int'(e_ill));
  endtask

  // Expected behaviour, organised by transaction kind
  task automatic predict();
    int  k = int'(op_class);
    int  m = int'(mcyc);
    bit  ok = 1;
    e_cyc = 0; e_addr = 0; e_data = 0;
    if (!req) begin
      e_tag = "R11";
    end else if (m == 1) begin
      e_cyc = (k == 15) ? 5 : 1; e_addr = int'(pc); e_tag = "R2";
    end else if (m == 2 && (k == 3 || k == 4 || k == 5 || k == 6 || k == 9 || k == 12 || k == 13)) begin
      e_cyc = 1; e_addr = int'(pc); e_tag = "R4";
    end else if (m == 3 && (k == 4 || k == 5 || k == 6)) begin
      e_cyc = 1; e_addr = int'(pc); e_tag = "R4";
    end else if (m == 2 && k == 1) begin
      e_cyc = 2; e_addr = int'(hl); e_data = int'(src); e_tag = "R3";
    end else if (m == 2 && (k == 2 || k == 7 || k == 8)) begin
      e_cyc = 1; e_addr = int'(hl); e_tag = "R5";
    end else if (m == 3 && k == 8) begin
      e_cyc = 2; e_addr = int'(hl); e_data = int'(tmp); e_tag = "R5";
    end else if (m == 3 && k == 9) begin
      e_cyc = 2; e_addr = int'(hl); e_data = int'(tmp); e_tag = "R6";
    end else if (m == 2 && (k == 10 || k == 11)) begin
      e_cyc = (k == 10) ? 1 : 2;
      e_addr = pair_sel ? int'(de) : int'(bc);
      e_data = (k == 11) ? int'(acc) : 0;
      e_tag = "R7";
    end else if (m == 4 && (k == 5 || k == 6)) begin
      e_cyc = (k == 5) ? 1 : 2; e_addr = int'(direct_addr);
      e_data = (k == 6) ? int'(acc) : 0; e_tag = "R8";
    end else if (m == 3 && (k == 12 || k == 13)) begin
      e_cyc = (k == 12) ? 3 : 4; e_addr = int'(tmp) * 256 + int'(tmp);
      e_data = (k == 13) ? int'(acc) : 0; e_tag = "R9";
    end else if (m == 2 && k == 14) begin
      e_cyc = 6; e_addr = int'(pc); e_tag = "R10";
    end else begin
      ok = 0; e_tag = "R12";
    end
    if (req && !ok) m_ill = 1;
    e_ill = m_ill;
  endtask

  task automatic step(bit r, int k, int m);
    int pc_c, a_c, d_c;
    @(negedge clk);
    compare_all(e_tag);
    pc_c = int'(cyc); a_c = int'(addr); d_c = int'(dout);
    req = r; op_class = 4'(k); mcyc = 3'(m);
    pair_sel = 1'($urandom);
    pc = 16'($urandom); hl = 16'($urandom); bc = 16'($urandom);
    de = 16'($urandom); direct_addr = 16'($urandom);
    acc = 8'($urandom); tmp = 8'($urandom); src = 8'($urandom);
    predict();
    #1;
    // R13: new inputs must not reach the outputs before the edge
    chk("R13", "cyc held", int'(cyc), pc_c);
    chk("R13", "addr held", int'(addr), a_c);
    chk("R13", "dout held", int'(dout), d_c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "cyc", int'(cyc), 0);
    chk("R1", "addr", int'(addr), 0);
    chk("R1", "dout", int'(dout), 0);
    chk("R1", "illegal", int'(illegal), 0);
    m_ill = 0; e_ill = 0; e_cyc = 0; e_addr = 0; e_data = 0; e_tag = "R1";
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    // legal sequences first, flag must stay low
    for (int k = 0; k < 16; k++) step(1, k, 1);
    for (int k = 1; k < 15; k++) begin
      if (k != 10 && k != 11) step(1, k, 2);
    end
    step(1, 10, 2); step(1, 10, 2); step(1, 11, 2); step(1, 11, 2);
    step(1, 4, 3); step(1, 5, 3); step(1, 6, 3); step(1, 8, 3);
    step(1, 9, 3); step(1, 12, 3); step(1, 13, 3);
    step(1, 5, 4); step(1, 6, 4);
    step(0, 1, 2); step(0, 13, 3);
    // undefined pair sets sticky flag, legal requests keep it
    step(1, 0, 2);
    step(1, 3, 2); step(0, 0, 0); step(1, 6, 4);
    do_reset();
    // exhaustive sweep of all pairs
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 16; k++) step(1, k, m);
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int mm = int'($urandom_range(1, 4));
      step(($urandom_range(0, 9) != 0), int'($urandom_range(0, 15)), mm);
    end
    step(0, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule